// File: doc/BRIEF.md
# Serial EEPROM Write Sequencer with Acknowledge Polling

This block sequences write transactions to a two-wire serial EEPROM at the byte level. It sits on top of a separate bit engine that generates START, STOP and byte transfers on the wire. Each transfer is a handshake: the sequencer holds a request with an operation code and a byte, and the engine answers with a done strobe and the sampled acknowledge bit. One command writes between one byte and one full page. The command carries a 3-bit chip select, a memory address and a byte count. Data bytes are fetched from an external buffer through an index output.

After the data the sequencer sends STOP, and the memory then starts its internal write cycle. The sequencer begins polling at once. It sends START and the write control byte, and repeats that pair for as long as the memory answers with a NACK. When the memory acknowledges, the sequencer closes with STOP and pulses `done`. A NACK during the transfer, a poll limit that runs out, or an illegal count each end the command with an error status. A host can therefore launch the next command as soon as `done` appears.

Top module: `eeprom_wr_seq`

## Requirements
- R1: Every control byte, whether for the write or for a poll, is `1010` followed by chip_sel[2:0] and then a 0 bit in the LSB.
- R2: After the control byte the sequencer sends the address high byte and then the low byte. The high byte carries mem_addr[ADDR_W-1:8] with its unused upper bits driven to 0, and the low byte is mem_addr[7:0].
- R3: Data bytes follow the address in index order 0 to byte_count-1. `buf_idx` presents the index of the byte being sent, and a request stays asserted with an unchanged operation until the engine reports done.
- R4: A byte_count of 0 or above PAGE_BYTES produces no engine request. `done` pulses on the cycle after `go`, and `status` is 1 (bad count).
- R5: A NACK on the write control byte, on either address byte or on any data byte is followed directly by STOP. The command then ends with `status` 2 (NACK).
- R6: After the data STOP the sequencer issues START and the control byte right away. Each NACK to that poll control byte is followed by another START, with no STOP in between.
- R7: When a poll control byte is acknowledged, the sequencer issues STOP and then pulses `done` with `status` 0.
- R8: When POLL_LIMIT consecutive poll control bytes are NACKed, the sequencer issues STOP and ends with `status` 3 (timeout).
- R9: `busy` is high from an accepted `go` until `done`, and a `go` that arrives while busy is ignored. Engine requests occur only while busy.
- R10: `done` is high for exactly one cycle per command.
- R11: After reset, `busy`, `done`, `eng_req` and `status` are all 0.
- R12: Engine operation codes are 0 for START, 1 for STOP and 2 for sending a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start a write command (sampled while idle) |
| chip_sel | input | 3 | Chip-select bits for the control byte |
| mem_addr | input | ADDR_W | Start address in the memory |
| byte_count | input | CNT_W | Number of data bytes, 1 to PAGE_BYTES |
| buf_idx | output | IDX_W | Index of the data byte being fetched |
| buf_data | input | 8 | Data byte at buf_idx |
| eng_req | output | 1 | Request to the bit engine, held until eng_done |
| eng_op | output | 2 | Engine operation: 0 START, 1 STOP, 2 byte |
| eng_byte | output | 8 | Byte to transmit when eng_op is 2 |
| eng_done | input | 1 | Engine finished the current request |
| eng_ack | input | 1 | Acknowledge sampled after a byte (1 = ACK) |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command strobe |
| status | output | 2 | Result: 0 ok, 1 bad count, 2 NACK, 3 poll timeout |

## Verification
The bench drives a single-byte write and a full 64-byte page at the top address. If the header were wrong, a byte would land at the wrong address. If the last-index compare were off by one, the page would lose its final byte or send a spare one. Polling runs with several NACKs and then with more NACKs than the limit allows. A sequencer that placed STOP between poll attempts would fail the queue comparison, and one whose limit was off by one would give up one poll early or late. NACKs injected on the control byte, on the high address byte and on a middle data byte check that every abort closes with STOP. Counts of 0 and 65, together with a stray `go` in the middle of a command, check that the sequencer neither starts a transfer it should reject nor latches a new command over a running one.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;

   // engine operation codes (R12)
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_BYTE  = 2'd2
   } eng_op_t;

   // command result codes
   typedef enum logic [1:0] {
      STAT_OK      = 2'd0,
      STAT_BADCNT  = 2'd1,
      STAT_NACK    = 2'd2,
      STAT_TIMEOUT = 2'd3
   } stat_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WSTART,
      ST_WCTRL,
      ST_AHI,
      ST_ALO,
      ST_DATA,
      ST_WSTOP,
      ST_PSTART,
      ST_PCTRL,
      ST_FSTOP,
      ST_ASTOP
   } seq_st_t;

   localparam logic [3:0] CTRL_PREFIX = 4'b1010;

endpackage

// File: rtl/eeprom_hdr_fmt.sv
module eeprom_hdr_fmt #(
   parameter int ADDR_W = 14
) (
   input  logic [2:0]        cs,
   input  logic [ADDR_W-1:0] addr,
   output logic [7:0]        ctrl_byte,
   output logic [7:0]        addr_hi,
   output logic [7:0]        addr_lo
);
   import eeprom_wr_pkg::*;

   localparam int HI_W = ADDR_W - 8;

   assign ctrl_byte = {CTRL_PREFIX, cs, 1'b0};
   assign addr_lo   = addr[7:0];

   generate
      if (HI_W == 8) begin : g_full_hi
         assign addr_hi = addr[ADDR_W-1:8];
      end else begin : g_pad_hi
         assign addr_hi = {{(8-HI_W){1'b0}}, addr[ADDR_W-1:8]};
      end
   endgenerate
endmodule

// File: rtl/eeprom_poll_lim.sv
module eeprom_poll_lim #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bump,
   output logic last
);
   generate
      if (LIMIT == 0) begin : g_unbounded
         assign last = 1'b0;
      end else begin : g_bounded
         localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
         logic [W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (clr)  cnt <= '0;
            else if (bump) cnt <= cnt + 1'b1;
         end
         assign last = (cnt == W'(LIMIT - 1));
      end
   endgenerate
endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq #(
   parameter int ADDR_W     = 14,
   parameter int PAGE_BYTES = 64,
   parameter int POLL_LIMIT = 1000,
   localparam int CNT_W     = $clog2(PAGE_BYTES + 1),
   localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [2:0]        chip_sel,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [CNT_W-1:0]  byte_count,
   output logic [IDX_W-1:0]  buf_idx,
   input  logic [7:0]        buf_data,
   output logic              eng_req,
   output logic [1:0]        eng_op,
   output logic [7:0]        eng_byte,
   input  logic              eng_done,
   input  logic              eng_ack,
   output logic              busy,
   output logic              done,
   output logic [1:0]        status
);
   import eeprom_wr_pkg::*;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
         $error("ADDR_W must lie in 9..16");
      end
      if (PAGE_BYTES < 2) begin : g_bad_page
         $error("PAGE_BYTES must be at least 2");
      end
   endgenerate

   seq_st_t             st;
   logic [2:0]          cs_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [IDX_W-1:0]    idx;
   stat_t               stat_q;
   logic                done_q;
   logic [7:0]          ctrl_b, ahi_b, alo_b;
   logic                poll_last;
   logic                last_data;
   logic                cnt_bad;

   eeprom_hdr_fmt #(.ADDR_W(ADDR_W)) u_fmt (
      .cs        (cs_q),
      .addr      (addr_q),
      .ctrl_byte (ctrl_b),
      .addr_hi   (ahi_b),
      .addr_lo   (alo_b)
   );

   eeprom_poll_lim #(.LIMIT(POLL_LIMIT)) u_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st == ST_WSTOP),
      .bump  (st == ST_PCTRL && eng_done && !eng_ack),
      .last  (poll_last)
   );

   assign cnt_bad   = (byte_count == '0) || (byte_count > CNT_W'(PAGE_BYTES));
   assign last_data = ((CNT_W'(idx) + 1'b1) == cnt_q);

   always_comb begin
      eng_req  = 1'b1;
      eng_op   = OP_BYTE;
      eng_byte = 8'h00;
      unique case (st)
         ST_WSTART, ST_PSTART:         eng_op = OP_START;
         ST_WCTRL, ST_PCTRL:           eng_byte = ctrl_b;
         ST_AHI:                       eng_byte = ahi_b;
         ST_ALO:                       eng_byte = alo_b;
         ST_DATA:                      eng_byte = buf_data;
         ST_WSTOP, ST_FSTOP, ST_ASTOP: eng_op = OP_STOP;
         default: begin
            eng_req = 1'b0;
            eng_op  = OP_START;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cs_q   <= '0;
         addr_q <= '0;
         cnt_q  <= '0;
         idx    <= '0;
         stat_q <= STAT_OK;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: if (go) begin
               if (cnt_bad) begin
                  stat_q <= STAT_BADCNT;
                  done_q <= 1'b1;
               end else begin
                  cs_q   <= chip_sel;
                  addr_q <= mem_addr;
                  cnt_q  <= byte_count;
                  idx    <= '0;
                  stat_q <= STAT_OK;
                  st     <= ST_WSTART;
               end
            end
            ST_WSTART: if (eng_done) st <= ST_WCTRL;
            ST_WCTRL, ST_AHI, ST_ALO: if (eng_done) begin
               if (!eng_ack) begin
                  stat_q <= STAT_NACK;
                  st     <= ST_ASTOP;
               end else if (st == ST_WCTRL) begin
                  st <= ST_AHI;
               end else if (st == ST_AHI) begin
                  st <= ST_ALO;
               end else begin
                  st <= ST_DATA;
               end
            end
            ST_DATA: if (eng_done) begin
               if (!eng_ack) begin
                  stat_q <= STAT_NACK;
                  st     <= ST_ASTOP;
               end else if (last_data) begin
                  st <= ST_WSTOP;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_WSTOP:  if (eng_done) st <= ST_PSTART;
            ST_PSTART: if (eng_done) st <= ST_PCTRL;
            ST_PCTRL: if (eng_done) begin
               if (eng_ack) begin
                  st <= ST_FSTOP;
               end else if (poll_last) begin
                  stat_q <= STAT_TIMEOUT;
                  st     <= ST_ASTOP;
               end else begin
                  st <= ST_PSTART;
               end
            end
            ST_FSTOP, ST_ASTOP: if (eng_done) begin
               done_q <= 1'b1;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign buf_idx = idx;
   assign busy    = (st != ST_IDLE);
   assign done    = done_q;
   assign status  = stat_q;
endmodule

// File: rtl/eeprom_wr_seq_chk.sv
module eeprom_wr_seq_chk
   import eeprom_wr_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic [1:0] status,
   input logic       eng_req,
   input logic [1:0] eng_op,
   input logic [7:0] eng_byte,
   input logic       eng_done,
   input logic       eng_ack,
   input seq_st_t    st,
   input logic [2:0] cs_q
);
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !eng_req);

   // R1
   ctrl_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_op == OP_BYTE && (st == ST_WCTRL || st == ST_PCTRL))
      |-> eng_byte == {4'b1010, cs_q, 1'b0});

   // R2
   hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && st == ST_AHI) |-> (16'(eng_byte) >> (ADDR_W - 8)) == 16'd0);

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_done) |=> (eng_req && $stable(eng_op)));

   // R5
   nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !eng_ack &&
       (st == ST_WCTRL || st == ST_AHI || st == ST_ALO || st == ST_DATA))
      |=> (eng_req && eng_op == OP_STOP));

   // R6
   poll_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && (st == ST_WSTOP || (st == ST_PCTRL && !eng_ack)))
      |=> (eng_req && eng_op == OP_START) || (done == 1'b0 && status == STAT_TIMEOUT));

   // R7
   ok_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == STAT_OK) |-> $past(eng_op) == OP_STOP);
endmodule

bind eeprom_wr_seq eeprom_wr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .status   (status),
   .eng_req  (eng_req),
   .eng_op   (eng_op),
   .eng_byte (eng_byte),
   .eng_done (eng_done),
   .eng_ack  (eng_ack),
   .st       (st),
   .cs_q     (cs_q)
);

// File: tb/tb_eeprom_wr_seq.sv
`timescale 1ns/1ps
module tb_eeprom_wr_seq;
   localparam int ADDR_W = 14;
   localparam int PAGE   = 64;
   localparam int LIMIT  = 5;
   localparam int CNT_W  = $clog2(PAGE + 1);
   localparam int IDX_W  = $clog2(PAGE);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go = 1'b0;
   logic [2:0] chip_sel = '0;
   logic [ADDR_W-1:0] mem_addr = '0;
   logic [CNT_W-1:0] byte_count = '0;
   logic [IDX_W-1:0] buf_idx;
   logic [7:0] buf_data;
   logic eng_req;
   logic [1:0] eng_op;
   logic [7:0] eng_byte;
   logic eng_done = 1'b0;
   logic eng_ack = 1'b0;
   logic busy, done;
   logic [1:0] status;

   logic [7:0] mem [PAGE];
   assign buf_data = mem[buf_idx];

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   eeprom_wr_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .POLL_LIMIT(LIMIT)) dut (
      .clk(clk), .rst_n(rst_n), .go(go), .chip_sel(chip_sel),
      .mem_addr(mem_addr), .byte_count(byte_count), .buf_idx(buf_idx),
      .buf_data(buf_data), .eng_req(eng_req), .eng_op(eng_op),
      .eng_byte(eng_byte), .eng_done(eng_done), .eng_ack(eng_ack),
      .busy(busy), .done(done), .status(status)
   );

   typedef struct {
      logic [1:0] op;
      logic [7:0] b;
      logic       ack;
      string      tag;
   } item_t;

   item_t exp_q[$];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] op, input logic [7:0] b,
                       input logic ack, input string tag);
      item_t it;
      it.op = op; it.b = b; it.ack = ack; it.tag = tag;
      exp_q.push_back(it);
   endtask

   // engine model and scoreboard monitor
   bit m_busy = 0;
   int m_cnt = 0;
   item_t cur;
   always @(negedge clk) begin
      if (!rst_n) begin
         eng_done = 1'b0;
         m_busy = 0;
      end else begin
         if (eng_done) begin
            eng_done = 1'b0;
            m_busy = 0;
         end
         if (m_busy) begin
            if (m_cnt == 0) begin
               eng_done = 1'b1;
               eng_ack  = cur.ack;
            end else begin
               m_cnt--;
            end
         end else if (eng_req) begin
            if (exp_q.size() == 0) begin
               check(0, "R9 unexpected request", int'(eng_op), 3);
               cur.ack = 1'b1; cur.op = eng_op; cur.b = eng_byte; cur.tag = "none";
            end else begin
               cur = exp_q.pop_front();
               check(eng_op == cur.op, {cur.tag, " R12 op"}, int'(eng_op), int'(cur.op));
               if (cur.op == 2'd2)
                  check(eng_byte == cur.b, {cur.tag, " byte"}, int'(eng_byte), int'(cur.b));
            end
            m_busy = 1;
            m_cnt = 2;
         end
      end
   end

   // driver: builds the expected stream, runs one command
   task automatic run_write(input logic [2:0] cs, input logic [ADDR_W-1:0] a,
                            input int n, input int nack_at, input int poll_nacks,
                            input bit stray_go, input string tag);
      logic [7:0] hdr [3];
      int exp_st;
      int wait_c;
      bit aborted;
      hdr[0] = {4'b1010, cs, 1'b0};
      hdr[1] = {2'b00, a[13:8]};
      hdr[2] = a[7:0];
      aborted = 0;
      exp_st = 0;
      push(2'd0, 8'h00, 1'b1, {tag, " R6 write start"});
      for (int k = 0; k < n + 3; k++) begin
         logic [7:0] b;
         string t;
         b = (k < 3) ? hdr[k] : mem[k-3];
         t = (k == 0) ? " R1 ctrl" : (k < 3) ? " R2 addr" : " R3 data";
         push(2'd2, b, (k != nack_at), {tag, t});
         if (k == nack_at) begin
            push(2'd1, 8'h00, 1'b1, {tag, " R5 abort stop"});
            exp_st = 2;
            aborted = 1;
            break;
         end
      end
      if (!aborted) begin
         push(2'd1, 8'h00, 1'b1, {tag, " R6 write stop"});
         for (int p = 0; ; p++) begin
            push(2'd0, 8'h00, 1'b1, {tag, " R6 poll start"});
            if (p < poll_nacks) begin
               push(2'd2, hdr[0], 1'b0, {tag, " R1 poll ctrl"});
               if (p == LIMIT - 1) begin
                  push(2'd1, 8'h00, 1'b1, {tag, " R8 timeout stop"});
                  exp_st = 3;
                  break;
               end
            end else begin
               push(2'd2, hdr[0], 1'b1, {tag, " R1 poll ctrl"});
               push(2'd1, 8'h00, 1'b1, {tag, " R7 final stop"});
               exp_st = 0;
               break;
            end
         end
      end
      @(negedge clk);
      chip_sel = cs; mem_addr = a; byte_count = CNT_W'(n); go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      check(busy == 1'b1, {tag, " R9 busy"}, int'(busy), 1);
      if (stray_go) begin
         repeat (5) @(negedge clk);
         chip_sel = 3'b000; mem_addr = '0; byte_count = CNT_W'(5); go = 1'b1;
         @(negedge clk);
         go = 1'b0;
      end
      wait_c = 0;
      while (!done && wait_c < 20000) begin
         @(negedge clk);
         wait_c++;
      end
      check(done == 1'b1, {tag, " R10 done seen"}, int'(done), 1);
      check(status == 2'(exp_st), {tag, " R5 R7 R8 status"}, int'(status), exp_st);
      check(busy == 1'b0, {tag, " R9 idle at done"}, int'(busy), 0);
      @(negedge clk);
      check(done == 1'b0, {tag, " R10 single pulse"}, int'(done), 0);
      check(exp_q.size() == 0, {tag, " R3 stream complete"}, exp_q.size(), 0);
   endtask

   task automatic run_bad(input int n, input string tag);
      @(negedge clk);
      byte_count = CNT_W'(n); go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      check(done == 1'b1, {tag, " R4 done next cycle"}, int'(done), 1);
      check(status == 2'd1, {tag, " R4 status"}, int'(status), 1);
      check(eng_req == 1'b0, {tag, " R4 no request"}, int'(eng_req), 0);
      @(negedge clk);
      check(done == 1'b0, {tag, " R10 single pulse"}, int'(done), 0);
      repeat (5) @(negedge clk);
      check(eng_req == 1'b0 && busy == 1'b0, {tag, " R4 stays idle"}, int'(busy), 0);
   endtask

   task automatic fill(input int seed);
      for (int i = 0; i < PAGE; i++) mem[i] = 8'(i * 7 + seed);
   endtask

   initial begin
      fill(3);
      repeat (3) @(negedge clk);
      // R11 reset state
      check(busy == 0 && done == 0 && eng_req == 0 && status == 0,
            "R11 reset state", {busy, done, eng_req, status}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_write(3'b101, 14'h2A5C, 1, -1, 0, 0, "single");
      fill(91);
      run_write(3'b010, 14'h3FFF, 64, -1, 3, 1, "page");
      run_bad(0, "count0");
      run_bad(65, "count65");
      run_write(3'b111, 14'h1234, 4, 1, 0, 0, "nack_ahi");
      fill(17);
      run_write(3'b001, 14'h0100, 6, 5, 0, 0, "nack_data");
      run_write(3'b110, 14'h0042, 2, 0, 0, 0, "nack_ctrl");
      run_write(3'b011, 14'h2000, 3, -1, 99, 0, "timeout");
      run_write(3'b100, 14'h0777, 2, -1, LIMIT - 1, 0, "poll_edge");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule